// File: doc/BRIEF.md
# Up/Down Reload Timer with Clock Output

This block is a 16-bit event counter paired with a 16-bit reload/capture register. Counting events come from one of three places. The first is an internal divider that ticks once every twelve clock cycles (timer mode). The second is a falling edge on an external count pin (counter mode). The third is a divide-by-two tick used when the block acts as a square-wave generator. A run bit gates all counting.

There are three ways to use it. As a plain up-counter, it reloads from the reload register on wrap and raises an overflow flag. As an up/down counter, the level of a second external pin picks the direction. The wrap in either direction toggles an extension flag that works as a seventeenth count bit. As a clock generator, each wrap reloads the count and toggles an output pin, with no interrupt. When the block is not in up/down mode, a falling edge on the control pin can force a reload or take a capture of the running count. Both flags stay set until the matching clear strobe arrives. A write port loads the count and the reload register directly.

Top module: `reload_timer16`

## Requirements
- R1: After reset, count_o, reload_o, ovf_flag, ext_flag, clk_out and irq are all 0.
- R2: In timer mode (cnt_sel=0, clkout_en=0), the count advances once every 12 clock cycles while run_en=1. With run_en=0 the count does not move.
- R3: In counter mode (cnt_sel=1), each falling edge of cnt_pin advances the count by one event. A steady pin advances nothing. Both pins pass through a two-flop synchronizer before edge detection.
- R4: Counting up (updown_en=0, or updown_en=1 with ctl_pin high), an event at count 16'hFFFF loads reload_o into the count and sets ovf_flag.
- R5: With updown_en=1 and ctl_pin low, each event decrements the count. An event while count equals reload_o loads 16'hFFFF and sets ovf_flag.
- R6: With updown_en=1, ext_flag toggles on every wrap in either direction and never drives irq. Falling edges on ctl_pin cause no reload or capture.
- R7: With updown_en=0, ext_en=1 and capture_sel=0, a falling edge on ctl_pin loads reload_o into the count and sets ext_flag. This happens even when run_en=0.
- R8: With updown_en=0, ext_en=1 and capture_sel=1, a falling edge on ctl_pin copies the count into reload_o and sets ext_flag.
- R9: With ext_en=0, edges on ctl_pin change neither the count, reload_o nor ext_flag.
- R10: With clkout_en=1 and cnt_sel=0, the count advances every 2 clock cycles. Each event at 16'hFFFF loads reload_o and toggles clk_out, and ovf_flag is not set. With cnt_sel=1, clock-output mode is off and counting follows R3.
- R11: ovf_flag and ext_flag are cleared only by a one-cycle clr_ovf or clr_ext strobe. A set in the same cycle wins over the clear.
- R12: irq is high when ovf_flag is set, or when ext_flag is set and updown_en=0.
- R13: wr_cnt loads wr_data into the count and wr_rel loads wr_data into reload_o on the next clock edge. wr_cnt also discards any count event in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (oscillator rate) |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enables counting |
| cnt_sel | input | 1 | 1 = count cnt_pin falling edges, 0 = internal tick |
| updown_en | input | 1 | Enables direction control by ctl_pin |
| ext_en | input | 1 | Enables reload/capture on ctl_pin falling edges |
| capture_sel | input | 1 | 1 = capture, 0 = reload on ctl_pin edge |
| clkout_en | input | 1 | Enables square-wave output mode |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| ctl_pin | input | 1 | External direction / trigger pin (asynchronous) |
| wr_cnt | input | 1 | Load count from wr_data |
| wr_rel | input | 1 | Load reload register from wr_data |
| wr_data | input | 16 | Write data |
| clr_ovf | input | 1 | Clears ovf_flag |
| clr_ext | input | 1 | Clears ext_flag |
| count_o | output | 16 | Current count |
| reload_o | output | 16 | Reload / capture register |
| ovf_flag | output | 1 | Wrap flag |
| ext_flag | output | 1 | External event / direction-wrap flag |
| irq | output | 1 | Interrupt request |
| clk_out | output | 1 | Square-wave output |

## Verification
Every change of the count, the reload register, the two flags and the clock-output pin is visible at the ports within one clock of the event that caused it. A corrupted count or a wrong wrap compare therefore shows up as a miscompare at the very next event: 12 cycles later in timer mode, 2 cycles later in clock-output mode. A wrong direction or a missed extension-flag toggle shows up on the first wrap in up/down mode. A spurious change while counting is stopped, or after an ignored pin edge, is caught as an unexpected transition in the first cycle it appears.

// File: rtl/rt16_pkg.sv
package rt16_pkg;
    localparam int CNT_W = 16;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rel;
        logic             ovf;
        logic             ext;
        logic             cko;
    } rt_state_t;
endpackage

// File: rtl/rt16_divider.sv
module rt16_divider #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == W'(DIV - 1));
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rt16_pinsync.sv
module rt16_pinsync #(
    parameter int NPIN   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] level_o,
    output logic [NPIN-1:0] fall_o
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        // STAGES synchronizer flops plus one history flop
        logic [STAGES:0] sh_d, sh_q;

        always_comb sh_d = {sh_q[STAGES-1:0], pin_i[i]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign level_o[i] = sh_q[STAGES-1];
        assign fall_o[i]  = sh_q[STAGES] & ~sh_q[STAGES-1];
    end
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16 #(
    parameter int TMR_DIV = 12,
    parameter int CKO_DIV = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run_en,
    input  logic                      cnt_sel,
    input  logic                      updown_en,
    input  logic                      ext_en,
    input  logic                      capture_sel,
    input  logic                      clkout_en,
    input  logic                      cnt_pin,
    input  logic                      ctl_pin,
    input  logic                      wr_cnt,
    input  logic                      wr_rel,
    input  logic [rt16_pkg::CNT_W-1:0] wr_data,
    input  logic                      clr_ovf,
    input  logic                      clr_ext,
    output logic [rt16_pkg::CNT_W-1:0] count_o,
    output logic [rt16_pkg::CNT_W-1:0] reload_o,
    output logic                      ovf_flag,
    output logic                      ext_flag,
    output logic                      irq,
    output logic                      clk_out
);
    import rt16_pkg::*;

    localparam int PIN_CNT = 0;
    localparam int PIN_CTL = 1;
    localparam int NPIN    = 2;

    rt_state_t st_d, st_q;

    logic            tick_slow, tick_fast;
    logic [NPIN-1:0] pin_raw, pin_lvl, pin_fall;
    logic            unused_cnt_lvl;
    logic            cko_mode, evt, ext_evt, count_down;

    rt16_divider #(.DIV(TMR_DIV)) u_div_slow (
        .clk(clk), .rst_n(rst_n), .tick_o(tick_slow)
    );

    rt16_divider #(.DIV(CKO_DIV)) u_div_fast (
        .clk(clk), .rst_n(rst_n), .tick_o(tick_fast)
    );

    assign pin_raw = {ctl_pin, cnt_pin};

    rt16_pinsync #(.NPIN(NPIN), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_raw),
        .level_o(pin_lvl), .fall_o(pin_fall)
    );

    assign unused_cnt_lvl = pin_lvl[PIN_CNT];

    always_comb begin
        st_d     = st_q;
        cko_mode = clkout_en & ~cnt_sel;

        if (cko_mode)     evt = tick_fast;
        else if (cnt_sel) evt = pin_fall[PIN_CNT];
        else              evt = tick_slow;
        evt = evt & run_en & ~wr_cnt;

        ext_evt    = ext_en & ~updown_en & ~cko_mode & pin_fall[PIN_CTL];
        count_down = updown_en & ~pin_lvl[PIN_CTL];

        if (clr_ovf) st_d.ovf = 1'b0;
        if (clr_ext) st_d.ext = 1'b0;

        if (evt) begin
            if (cko_mode) begin
                if (st_q.cnt == '1) begin
                    st_d.cnt = st_q.rel;
                    st_d.cko = ~st_q.cko;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else if (count_down) begin
                if (st_q.cnt == st_q.rel) begin
                    st_d.cnt = '1;
                    st_d.ovf = 1'b1;
                    st_d.ext = ~st_d.ext;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end else begin
                if (st_q.cnt == '1) begin
                    st_d.cnt = st_q.rel;
                    st_d.ovf = 1'b1;
                    if (updown_en) st_d.ext = ~st_d.ext;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end

        if (ext_evt) begin
            if (capture_sel) st_d.rel = st_q.cnt;
            else             st_d.cnt = st_q.rel;
            st_d.ext = 1'b1;
        end

        if (wr_cnt) st_d.cnt = wr_data;
        if (wr_rel) st_d.rel = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o  = st_q.cnt;
    assign reload_o = st_q.rel;
    assign ovf_flag = st_q.ovf;
    assign ext_flag = st_q.ext;
    assign clk_out  = st_q.cko;
    assign irq      = st_q.ovf | (st_q.ext & ~updown_en);
endmodule

// File: rtl/rt16_checker.sv
module rt16_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        run_en,
    input logic        cnt_sel,
    input logic        updown_en,
    input logic        ext_en,
    input logic        clkout_en,
    input logic        wr_cnt,
    input logic        wr_rel,
    input logic        clr_ovf,
    input logic        clr_ext,
    input logic [15:0] count_o,
    input logic [15:0] reload_o,
    input logic        ovf_flag,
    input logic        ext_flag,
    input logic        clk_out
);
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_cnt && !ext_en) |=> $stable(count_o)); // R2

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_ovf) |=> ovf_flag); // R11

    AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_flag && !clr_ext && !updown_en) |=> ext_flag); // R11

    AST_CKO_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (clkout_en && !cnt_sel && !ovf_flag) |=> !ovf_flag); // R10

    AST_CKO_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(clk_out) && !$past(wr_rel)) |-> (count_o == reload_o)); // R10

    AST_REL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_rel && !ext_en) |=> $stable(reload_o)); // R8
endmodule

bind reload_timer16 rt16_checker u_chk (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_sel(cnt_sel),
    .updown_en(updown_en), .ext_en(ext_en), .clkout_en(clkout_en),
    .wr_cnt(wr_cnt), .wr_rel(wr_rel), .clr_ovf(clr_ovf), .clr_ext(clr_ext),
    .count_o(count_o), .reload_o(reload_o), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .clk_out(clk_out)
);

// File: tb/reload_timer16_bench.sv
`timescale 1ns/1ps
module reload_timer16_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 0, cnt_sel = 0, updown_en = 0, ext_en = 0, capture_sel = 0, clkout_en = 0;
    logic cnt_pin = 0, ctl_pin = 0, wr_cnt = 0, wr_rel = 0, clr_ovf = 0, clr_ext = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_o, reload_o;
    logic ovf_flag, ext_flag, irq, clk_out;

    always #10 clk = ~clk; // 50 MHz

    reload_timer16 u_reload_timer16 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_sel(cnt_sel),
        .updown_en(updown_en), .ext_en(ext_en), .capture_sel(capture_sel),
        .clkout_en(clkout_en), .cnt_pin(cnt_pin), .ctl_pin(ctl_pin),
        .wr_cnt(wr_cnt), .wr_rel(wr_rel), .wr_data(wr_data),
        .clr_ovf(clr_ovf), .clr_ext(clr_ext), .count_o(count_o),
        .reload_o(reload_o), .ovf_flag(ovf_flag), .ext_flag(ext_flag),
        .irq(irq), .clk_out(clk_out)
    );

    typedef struct packed {
        logic [15:0] cnt;
        logic [15:0] rel;
        logic        tf;
        logic        exf;
        logic        ck;
    } snap_t;

    snap_t exp_q[$];
    string tag_q[$];
    int    n_chk = 0, n_fail = 0;
    int    cyc = 0, t_last = 0, t_prev = 0;
    bit    mon_on = 0, done = 0;
    snap_t prev_s;

    // reference state
    logic [15:0] m_cnt = 0, m_rel = 0;
    logic        m_tf = 0, m_exf = 0, m_ck = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired (all R) actual=%0d expected<=50000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // monitor: every visible state change must match the next expected snapshot
    always @(negedge clk) begin
        if (mon_on) begin
            snap_t cur, e;
            string tg;
            cur = '{count_o, reload_o, ovf_flag, ext_flag, clk_out};
            if (cur != prev_s) begin
                t_prev = t_last;
                t_last = cyc;
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2/R6/R9 unexpected change actual=%h expected=%h", cur, prev_s);
                end else begin
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    if (cur != e) begin
                        n_fail++;
                        $display("FAIL %s actual=%h expected=%h", tg, cur, e);
                    end
                end
                prev_s = cur;
            end
        end
    end

    task automatic push(string tag);
        exp_q.push_back('{m_cnt, m_rel, m_tf, m_exf, m_ck});
        tag_q.push_back(tag);
    endtask

    task automatic step(int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drain();
        int k = 0;
        while (exp_q.size() != 0 && k < 3000) begin
            @(negedge clk);
            k++;
        end
        #1;
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL %s missing change actual=none expected=%h", tag_q[0], exp_q[0]);
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // one count event as the requirements define it
    task automatic model_evt(string tag);
        if (clkout_en && !cnt_sel) begin
            if (m_cnt == 16'hFFFF) begin m_cnt = m_rel; m_ck = ~m_ck; end
            else m_cnt = m_cnt + 1;
        end else if (updown_en && !ctl_pin) begin
            if (m_cnt == m_rel) begin m_cnt = 16'hFFFF; m_tf = 1; m_exf = ~m_exf; end
            else m_cnt = m_cnt - 1;
        end else begin
            if (m_cnt == 16'hFFFF) begin
                m_cnt = m_rel; m_tf = 1;
                if (updown_en) m_exf = ~m_exf;
            end else m_cnt = m_cnt + 1;
        end
        push(tag);
    endtask

    task automatic write_cnt(logic [15:0] v);
        m_cnt = v; push("R13 count write");
        wr_data = v; wr_cnt = 1; step(); wr_cnt = 0; drain();
    endtask

    task automatic write_rel(logic [15:0] v);
        m_rel = v; push("R13 reload write");
        wr_data = v; wr_rel = 1; step(); wr_rel = 0; drain();
    endtask

    task automatic clear_flags(bit a, bit b, string tag);
        if ((a && m_tf) || (b && m_exf)) begin
            if (a) m_tf = 0;
            if (b) m_exf = 0;
            push(tag);
        end
        clr_ovf = a; clr_ext = b; step(); clr_ovf = 0; clr_ext = 0; drain();
    endtask

    task automatic pulse_ctl();
        ctl_pin = 1; step(6); ctl_pin = 0;
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step(2);
        // R1 reset state
        chk("R1 count", count_o, 0);
        chk("R1 reload", reload_o, 0);
        chk("R1 flags", {ovf_flag, ext_flag, clk_out}, 0);
        chk("R1 irq", irq, 0);
        prev_s = '{count_o, reload_o, ovf_flag, ext_flag, clk_out};
        mon_on = 1;

        // R13, R4, R2: up count through wrap in timer mode
        write_rel(16'hFFF0);
        write_cnt(16'hFFFD);
        model_evt("R2 timer step"); model_evt("R2 timer step");
        model_evt("R4 wrap reloads, sets flag"); model_evt("R4 after wrap");
        run_en = 1; drain(); run_en = 0;
        chk("R2 tick spacing", t_last - t_prev, 12);
        chk("R12 irq on ovf", irq, 1);

        // R2 hold when stopped, R11 flag sticky
        step(40);
        chk("R2 held count", count_o, m_cnt);
        chk("R11 ovf still set", ovf_flag, 1);
        clear_flags(1, 0, "R11 ovf clear");
        chk("R12 irq low", irq, 0);

        // R3 counter mode
        cnt_sel = 1; run_en = 1;
        for (int i = 0; i < 3; i++) begin
            cnt_pin = 1; step(5);
            model_evt("R3 pin edge count");
            cnt_pin = 0; step(5); drain();
        end
        step(30);
        chk("R3 steady pin", count_o, m_cnt);
        run_en = 0; cnt_sel = 0;

        // R5, R6 down count, then up count in up/down mode
        updown_en = 1; step(5);
        write_cnt(16'hFFF3);
        for (int i = 0; i < 5; i++) model_evt("R5 down count / wrap to FFFF");
        run_en = 1; drain(); run_en = 0;
        chk("R6 ext toggled to 1", ext_flag, 1);
        chk("R12 irq from ovf", irq, 1);
        clear_flags(1, 0, "R11 ovf clear");
        chk("R6 ext gives no irq", irq, 0);
        ext_en = 1; ctl_pin = 1; step(6);
        model_evt("R6 up count"); model_evt("R6 up wrap toggles ext back");
        run_en = 1; drain(); run_en = 0;
        chk("R6 ext toggled to 0", ext_flag, 0);
        ctl_pin = 0; step(10); // falling edge in up/down mode: ignored
        chk("R6 no reload on edge", count_o, m_cnt);
        clear_flags(1, 1, "R11 clear both");
        updown_en = 0; ext_en = 0; step(2);

        // R9 edges ignored when disabled
        write_cnt(16'h1234);
        pulse_ctl(); step(8);
        chk("R9 count kept", count_o, 16'h1234);
        chk("R9 ext kept", ext_flag, 0);

        // R7 reload on edge, run off
        ext_en = 1; capture_sel = 0;
        pulse_ctl();
        m_cnt = m_rel; m_exf = 1; push("R7 edge reload");
        drain(); step(4);
        chk("R12 irq on ext", irq, 1);
        clear_flags(0, 1, "R11 ext clear");

        // R8 capture
        capture_sel = 1;
        write_cnt(16'hABCD);
        pulse_ctl();
        m_rel = 16'hABCD; m_exf = 1; push("R8 edge capture");
        drain(); step(4);
        clear_flags(0, 1, "R11 ext clear");
        ext_en = 0; capture_sel = 0;

        // R10 clock output
        clkout_en = 1;
        write_rel(16'hFFFE);
        write_cnt(16'hFFFD);
        for (int i = 0; i < 5; i++) model_evt("R10 clock-out step / toggle");
        run_en = 1; drain(); run_en = 0;
        chk("R10 fast tick spacing", t_last - t_prev, 2);
        chk("R10 no ovf", ovf_flag, 0);
        chk("R10 clk_out after two wraps", clk_out, 0);
        chk("R10 irq low", irq, 0);

        // R10 counter select blocks clock-out mode
        cnt_sel = 1; run_en = 1; step(30);
        chk("R10 no fast count with cnt_sel", count_o, m_cnt);
        run_en = 0; cnt_sel = 0; clkout_en = 0;
        step(5);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule